// File: doc/BRIEF.md
# Fastlock Charge Pump Timer

This block governs a temporary high-current state of a synthesizer's charge pump that shortens frequency acquisition. Software stores a gain request bit with every divider load. When fastlock is enabled, a request of 1 puts the loop into the high-current state, drives the fastlock pin low so that an external loop-filter resistor is switched in, and, in the timed mode, starts a countdown measured in phase-detector cycles. When the countdown runs out, the block leaves fastlock and sends a one-cycle strobe so that the stored gain bit is cleared.

Two exit modes exist. In the manual mode, only a later write of 0 ends fastlock. In the timed mode, a 4-bit code chooses a timeout of 3 + 4 × code detector cycles, from 3 up to 63. When fastlock is disabled, the fastlock pin just follows the mode bit, which lets that bit act as a general-purpose output level. A force input, driven by power-down or by the initialization reset, holds the countdown at its load value.

Top module: `fastlock_timer`

## Requirements
- R1: After reset, hi_current and gain_clr are 0.
- R2: While fl_enable is 0, fl_pin equals fl_mode, and gain writes leave hi_current at 0.
- R3: While fl_enable is 1 and fastlock is not active, fl_pin is 1.
- R4: A gain write (gain_wr=1, gain_val=1) with fl_enable=1 raises hi_current one clock later, and fl_pin is 0 while it is high.
- R5: With fl_mode=0 (manual), hi_current stays high however many pd_tick pulses arrive. It falls one clock after a gain write with gain_val=0.
- R6: With fl_mode=1 (timed), hi_current falls on the clock edge that samples the T-th pd_tick after entry, where T = 3 + 4 × tmo_code. gain_clr is high for exactly that one following cycle.
- R7: A new gain write of 1 during an active countdown restarts the count from the full T.
- R8: While force_rst is 1, pd_tick pulses are not counted and the countdown is held at T. After release, a full T ticks are needed before expiry. force_rst does not itself end fastlock.
- R9: A gain write of 0 in the timed mode ends fastlock one clock later, and gain_clr stays 0.
- R10: If fl_enable falls while fastlock is active, hi_current is 0 one clock later and gain_clr stays 0.
- R11: tmo_code 0 gives a timeout of 3 ticks and tmo_code 15 gives 63 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_enable | input | 1 | Fastlock enable bit |
| fl_mode | input | 1 | 0 = manual exit, 1 = timed exit; the pin level when disabled |
| tmo_code | input | 4 | Timeout code, T = 3 + 4 × code ticks |
| gain_wr | input | 1 | One-cycle strobe: a divider load carrying a gain bit |
| gain_val | input | 1 | Gain bit value that accompanies gain_wr |
| pd_tick | input | 1 | One pulse per phase-detector cycle |
| force_rst | input | 1 | Holds the timeout counter at its load value |
| hi_current | output | 1 | Selects the high charge pump current |
| fl_pin | output | 1 | Fastlock pin level |
| gain_clr | output | 1 | One-cycle strobe that clears the stored gain bit |

## Verification
The hardest situations to reach are the ones where a countdown is disturbed partway through: a rewrite of 1 after several ticks, or a force pulse that arrives mid-count while ticks keep coming. The stimulus enters timed fastlock, delivers a counted number of ticks, and then applies the rewrite or the force. It then measures the ticks up to gain_clr and expects the full T. A randomized phase mixes writes, mode and enable changes, and force pulses, while a behavioural model is compared with the outputs on every clock.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef struct packed {
        logic active;
        logic clr;
    } fl_state_t;
endpackage

// File: rtl/fl_tmo_decode.sv
module fl_tmo_decode #(
    parameter int CODE_W = 4,
    parameter int BASE   = 3,
    parameter int STEP   = 4,
    parameter int CNT_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  span
);
    always_comb begin
        span = CNT_W'(BASE + STEP * int'(code));
    end
endmodule

// File: rtl/fl_countdown.sv
module fl_countdown #(
    parameter int CNT_W = 6,
    parameter int MAXT  = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hold,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d   = cd_q;
        expire = 1'b0;
        if (load || hold) begin
            cd_d.cnt = load_val;
        end else if (run && tick) begin
            if (cd_q.cnt <= CNT_W'(1)) begin
                cd_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    // The count never exceeds the longest coded timeout.
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cd_q.cnt <= CNT_W'(MAXT));
    // A held counter sits at a full timeout (at least 2), so it cannot expire on the next tick.
    a_r8_hold_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !expire);
endmodule

// File: rtl/fl_pin_drive.sv
module fl_pin_drive (
    input  logic enable,
    input  logic mode,
    input  logic active,
    output logic pin
);
    always_comb begin
        if (!enable) pin = mode;
        else         pin = !active;
    end
endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
    parameter int CODE_W = 4,
    parameter int BASE   = 3,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_enable,
    input  logic              fl_mode,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              gain_wr,
    input  logic              gain_val,
    input  logic              pd_tick,
    input  logic              force_rst,
    output logic              hi_current,
    output logic              fl_pin,
    output logic              gain_clr
);
    import fl_pkg::*;

    localparam int MAXT  = BASE + STEP * ((1 << CODE_W) - 1);
    localparam int CNT_W = $clog2(MAXT + 1);

    fl_state_t st_d, st_q;
    logic [CNT_W-1:0] span;
    logic enter, run, expire;

    fl_tmo_decode #(.CODE_W(CODE_W), .BASE(BASE), .STEP(STEP), .CNT_W(CNT_W)) u_dec (
        .code (tmo_code),
        .span (span)
    );

    assign enter = fl_enable && gain_wr && gain_val;
    assign run   = fl_enable && fl_mode && st_q.active && !gain_wr;

    fl_countdown #(.CNT_W(CNT_W), .MAXT(MAXT)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter),
        .hold     (force_rst),
        .run      (run),
        .tick     (pd_tick),
        .load_val (span),
        .expire   (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (!fl_enable) begin
            st_d.active = 1'b0;
        end else if (gain_wr) begin
            st_d.active = gain_val;
        end else if (expire) begin
            st_d.active = 1'b0;
            st_d.clr    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fl_pin_drive u_pin (
        .enable (fl_enable),
        .mode   (fl_mode),
        .active (st_q.active),
        .pin    (fl_pin)
    );

    assign hi_current = st_q.active;
    assign gain_clr   = st_q.clr;

    a_r10_disable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_enable |=> !hi_current);
    a_r2_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_enable && !hi_current) |=> !hi_current);
    a_r5_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_enable && !fl_mode && hi_current && !gain_wr) |=> hi_current);
    a_r6_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |=> !gain_clr);
    a_r6_clr_ends: assert property (@(posedge clk) disable iff (!rst_n)
        gain_clr |-> (!hi_current && $past(hi_current)));
    a_r4_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_current && fl_enable) |-> !fl_pin);
endmodule

// File: tb/fastlock_timer_test.sv
module fastlock_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, mode = 1'b0, wr = 1'b0, val = 1'b0, tick = 1'b0, frc = 1'b0;
    logic [3:0] code = 4'd0;
    logic hi, pin, clr;
    int checks = 0, errors = 0;
    string tag = "R1";

    bit m_act = 0, m_clr = 0;
    int m_rem = 0;

    always #2 clk = ~clk;

    fastlock_timer uut (
        .clk(clk), .rst_n(rst_n), .fl_enable(en), .fl_mode(mode),
        .tmo_code(code), .gain_wr(wr), .gain_val(val), .pd_tick(tick),
        .force_rst(frc), .hi_current(hi), .fl_pin(pin), .gain_clr(clr)
    );

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit old_act, exp_now;
        old_act = m_act;
        if (!rst_n) begin
            m_act = 0; m_clr = 0; m_rem = 0;
            return;
        end
        exp_now = en && mode && old_act && !wr && !frc && tick && (m_rem <= 1);
        if (!en)         m_act = 0;
        else if (wr)     m_act = val;
        else if (exp_now) m_act = 0;
        m_clr = exp_now;
        if ((en && wr && val) || frc) m_rem = 3 + 4 * code;
        else if (en && mode && old_act && !wr && tick) m_rem = (m_rem <= 1) ? 0 : m_rem - 1;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        chk({tag, " hi_current"}, hi, m_act);
        chk({tag, " gain_clr"}, clr, m_clr);
        chk({tag, " fl_pin"}, pin, en ? !m_act : mode);
    endtask

    task automatic write_gain(input bit v);
        wr = 1; val = v; cyc(); wr = 0;
    endtask

    task automatic measure(input int exp_t, input string t);
        int n;
        n = 0;
        tick = 1;
        for (int i = 0; i < 80; i++) begin
            cyc();
            n++;
            if (clr) break;
        end
        tick = 0;
        chk({t, " ticks to expiry"}, n, exp_t);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R1 hi after reset", hi, 0);
        chk("R1 clr after reset", clr, 0);

        // R2: disabled, pin follows mode, writes ignored
        tag = "R2";
        mode = 1; cyc(); chk("R2 pin=mode 1", pin, 1);
        mode = 0; cyc(); chk("R2 pin=mode 0", pin, 0);
        write_gain(1); cyc(); chk("R2 write ignored", hi, 0);

        // R3: enabled idle pin high
        tag = "R3";
        en = 1; cyc(); chk("R3 idle pin", pin, 1);

        // R4/R5: manual mode
        tag = "R5";
        mode = 0; write_gain(1);
        chk("R4 hi after write", hi, 1);
        chk("R4 pin low", pin, 0);
        tick = 1; repeat (100) cyc(); tick = 0;
        chk("R5 still high after ticks", hi, 1);
        write_gain(0);
        chk("R5 exit on write 0", hi, 0);

        // R6/R11: timed mode, extremes of the code
        tag = "R6";
        mode = 1; code = 0; write_gain(1);
        measure(3, "R11 code0");
        chk("R6 hi low at expiry", hi, 0);
        cyc(); chk("R6 clr single cycle", clr, 0);
        code = 15; write_gain(1);
        measure(63, "R11 code15");
        code = 2; write_gain(1);
        measure(11, "R6 code2");

        // R7: restart on rewrite
        tag = "R7";
        code = 1; write_gain(1);
        tick = 1; repeat (5) cyc(); tick = 0;
        write_gain(1);
        measure(7, "R7 restart");

        // R8: force holds the counter
        tag = "R8";
        code = 0; write_gain(1);
        tick = 1; repeat (2) cyc();
        frc = 1; repeat (5) cyc(); frc = 0; tick = 0;
        chk("R8 force keeps fastlock", hi, 1);
        measure(3, "R8 full after force");

        // R9: early exit by write 0 in timed mode
        tag = "R9";
        code = 3; write_gain(1);
        tick = 1; repeat (4) cyc(); tick = 0;
        write_gain(0);
        chk("R9 hi low", hi, 0);
        chk("R9 no clr", clr, 0);

        // R10: enable drop
        tag = "R10";
        write_gain(1);
        en = 0; cyc();
        chk("R10 hi low", hi, 0);
        chk("R10 no clr", clr, 0);
        en = 1; cyc();

        // Random mix compared against the model
        tag = "R6 random";
        for (int i = 0; i < 3000; i++) begin
            en   = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 49) == 0) mode = ~mode;
            code = 4'($urandom_range(0, 3));
            wr   = ($urandom_range(0, 29) == 0);
            val  = ($urandom_range(0, 3) != 0);
            tick = ($urandom_range(0, 1) != 0);
            frc  = ($urandom_range(0, 39) == 0);
            cyc();
        end
        wr = 0; frc = 0; tick = 0;
        cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule